// File: doc/BRIEF.md
# Wake-up and kickstart power sequencer

This block decides when a system supplied by a real-time clock should be powered. While the system is unpowered, it watches two inputs: a debounced external kickstart line and a strobe from the alarm comparator. When either event occurs and is enabled, the block raises an open-drain power request. It then gives the supply a bounded number of cycles to come up. A missed window drops the request but keeps the flag, so software can see the cause at the next successful power-up.

Once the supply is good, the block drives the shared open-drain interrupt line whenever an enabled flag or an external source is pending. It keeps the power request asserted while the power-off control bit is clear. Software clears flags by writing zeros and powers the system down by setting the power-off bit. Both open-drain pins are modelled as pull-low enables. A 5-bit control word is written in one cycle and can be read back.

Control word layout: bit 0 wake flag, bit 1 kickstart flag, bit 2 wake enable, bit 3 kickstart enable, bit 4 power-off.

Top module: `wake_kick_seq`

## Requirements
- R1: A kickstart event is recognised only when the synchronised kickstart input stays low for at least KS_MIN_CYC consecutive clock cycles. A shorter low pulse is ignored, and one low period yields at most one event.
- R2: While unpowered, a kickstart event with kickstart enable (bit 3) set sets the kickstart flag (bit 1) and asserts `pwr_oe_o`. With bit 3 clear, the event changes neither the flag nor `pwr_oe_o`.
- R3: While unpowered, an alarm strobe with wake enable (bit 2) set sets the wake flag (bit 0) and asserts `pwr_oe_o`. With bit 2 clear, the strobe changes neither the flag nor `pwr_oe_o`.
- R4: If `supply_good_i` is not seen within TIMEOUT_CYC cycles of the request, `pwr_oe_o` is released and the flag stays set. `irq_oe_o` stays low for the whole attempt.
- R5: If `supply_good_i` arrives within the window, the power-off bit (bit 4) is cleared, `pwr_oe_o` stays asserted, and `irq_oe_o` reports the enabled flag that caused the power-up.
- R6: A written 0 clears a flag bit and a written 1 leaves it unchanged. The enable and power-off bits take the written value. Once flags are cleared, `irq_oe_o` goes low unless `other_irq_i` is high.
- R7: While powered, kickstart events and alarm strobes set their flags regardless of the enables. `irq_oe_o` is the OR of (flag AND enable) for each source and `other_irq_i`.
- R8: While powered, an enabled wake or kickstart event clears the power-off bit and asserts `pwr_oe_o`. This also applies when power arrived without a request.
- R9: Writing 1 to the power-off bit while powered releases `pwr_oe_o`. When `supply_good_i` falls, `irq_oe_o` is released on the next cycle.
- R10: After reset, `pwr_oe_o` and `irq_oe_o` are 0 and the control word reads 5'b10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ks_n_i | input | 1 | Asynchronous kickstart input, active low |
| alarm_i | input | 1 | One-cycle alarm-match strobe |
| supply_good_i | input | 1 | System supply above the backup and power-fail levels |
| other_irq_i | input | 1 | Another interrupt source is pending |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 5 | Control word write data |
| ctrl_o | output | 5 | Current control word |
| pwr_oe_o | output | 1 | 1 pulls the power-request line low |
| irq_oe_o | output | 1 | 1 pulls the interrupt line low |

## Verification
The assertions assume that `supply_good_i` changes only between clock edges and that `alarm_i` is a clean strobe in the clock domain. They also assume that writes to the control word are single-cycle pulses. The bench drives every input on the falling clock edge and holds the kickstart line steady for whole cycles. It raises the supply well inside the timeout window, or withholds it well past the window, so that no check depends on a single-cycle race between the supply and the timeout.

// File: rtl/wks_pkg.sv
package wks_pkg;
  typedef enum logic [1:0] {
    ST_DOWN   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ON     = 2'd2,
    ST_OFFING = 2'd3
  } seq_state_t;

  localparam int unsigned CW_W   = 5;
  localparam int unsigned B_WF   = 0;
  localparam int unsigned B_KF   = 1;
  localparam int unsigned B_WIE  = 2;
  localparam int unsigned B_KSE  = 3;
  localparam int unsigned B_POFF = 4;
endpackage

// File: rtl/wks_ks_filter.sv
module wks_ks_filter #(
  parameter int unsigned KS_MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ks_n_i,
  output logic ks_evt_o
);
  localparam int unsigned CW = $clog2(KS_MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(KS_MIN_CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(KS_MIN_CYC);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= ks_n_i;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (sync2_q) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != SAT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ks_evt_o = !sync2_q && (cnt_q == LAST);

  AST_KS_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ks_evt_o |=> !ks_evt_o); // R1
endmodule

// File: rtl/wks_regs.sv
module wks_regs
  import wks_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [CW_W-1:0] wr_data_i,
  input  logic            set_wf_i,
  input  logic            set_kf_i,
  input  logic            clr_poff_i,
  output logic [CW_W-1:0] ctrl_o
);
  logic [CW_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d[B_WF]   = ctrl_q[B_WF] & wr_data_i[B_WF];
      ctrl_d[B_KF]   = ctrl_q[B_KF] & wr_data_i[B_KF];
      ctrl_d[B_WIE]  = wr_data_i[B_WIE];
      ctrl_d[B_KSE]  = wr_data_i[B_KSE];
      ctrl_d[B_POFF] = wr_data_i[B_POFF];
    end
    if (set_wf_i)   ctrl_d[B_WF]   = 1'b1;
    if (set_kf_i)   ctrl_d[B_KF]   = 1'b1;
    if (clr_poff_i) ctrl_d[B_POFF] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CW_W'(1) << B_POFF;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_KF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_KF] && !wr_en_i) |=> ctrl_q[B_KF]); // R4
  AST_WF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_wf_i |=> ctrl_q[B_WF]); // R3
endmodule

// File: rtl/wks_fsm.sv
module wks_fsm
  import wks_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ks_evt_i,
  input  logic alarm_i,
  input  logic supply_good_i,
  input  logic other_irq_i,
  input  logic wf_i,
  input  logic kf_i,
  input  logic wie_i,
  input  logic kse_i,
  input  logic poff_i,
  output logic set_wf_o,
  output logic set_kf_o,
  output logic clr_poff_o,
  output logic pwr_oe_o,
  output logic irq_oe_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  seq_state_t    st_q, st_d;
  logic [TW-1:0] tmo_q;
  logic          tmo_hit, powered, ev_en;

  assign powered = (st_q == ST_ON) || (st_q == ST_OFFING);
  assign ev_en   = (ks_evt_i && kse_i) || (alarm_i && wie_i);
  assign tmo_hit = (tmo_q == T_LAST);

  always_comb begin
    st_d       = st_q;
    clr_poff_o = 1'b0;
    set_kf_o   = ks_evt_i && (kse_i || powered);
    set_wf_o   = alarm_i && (wie_i || powered);
    unique case (st_q)
      ST_DOWN: begin
        if (ev_en)              st_d = ST_WAIT;
        else if (supply_good_i) st_d = ST_OFFING;
      end
      ST_WAIT: begin
        if (supply_good_i) begin
          st_d       = ST_ON;
          clr_poff_o = 1'b1;
        end else if (tmo_hit) begin
          st_d = ST_DOWN;
        end
      end
      ST_ON: begin
        if (!supply_good_i) st_d = ST_DOWN;
        else if (ev_en)     clr_poff_o = 1'b1;
        else if (poff_i)    st_d = ST_OFFING;
      end
      ST_OFFING: begin
        if (!supply_good_i) st_d = ST_DOWN;
        else if (ev_en) begin
          st_d       = ST_ON;
          clr_poff_o = 1'b1;
        end else if (!poff_i) begin
          st_d = ST_ON;
        end
      end
      default: st_d = ST_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_DOWN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tmo_q <= '0;
    else if (st_q != ST_WAIT) tmo_q <= '0;
    else if (!tmo_hit)        tmo_q <= tmo_q + 1'b1;
  end

  assign pwr_oe_o = (st_q == ST_WAIT) || (powered && !poff_i);
  assign irq_oe_o = powered &&
                    ((wf_i && wie_i) || (kf_i && kse_i) || other_irq_i);

  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && tmo_hit && !supply_good_i) |=> !pwr_oe_o); // R4
  AST_NO_IRQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !irq_oe_o); // R4
  AST_POFF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && supply_good_i) |=> (!poff_i && pwr_oe_o)); // R5
  AST_IRQ_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_good_i) |=> !irq_oe_o); // R9
  AST_EVENT_POWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && supply_good_i && ev_en) |=> pwr_oe_o); // R8
endmodule

// File: rtl/wake_kick_seq.sv
module wake_kick_seq
  import wks_pkg::*;
#(
  parameter int unsigned KS_MIN_CYC  = 8,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ks_n_i,
  input  logic            alarm_i,
  input  logic            supply_good_i,
  input  logic            other_irq_i,
  input  logic            wr_en_i,
  input  logic [CW_W-1:0] wr_data_i,
  output logic [CW_W-1:0] ctrl_o,
  output logic            pwr_oe_o,
  output logic            irq_oe_o
);
  logic rst_m_q, rst_s_q;
  logic ks_evt, set_wf, set_kf, clr_poff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  wks_ks_filter #(.KS_MIN_CYC(KS_MIN_CYC)) u_filt (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .ks_n_i   (ks_n_i),
    .ks_evt_o (ks_evt)
  );

  wks_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .set_wf_i   (set_wf),
    .set_kf_i   (set_kf),
    .clr_poff_i (clr_poff),
    .ctrl_o     (ctrl_o)
  );

  wks_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_s_q),
    .ks_evt_i      (ks_evt),
    .alarm_i       (alarm_i),
    .supply_good_i (supply_good_i),
    .other_irq_i   (other_irq_i),
    .wf_i          (ctrl_o[B_WF]),
    .kf_i          (ctrl_o[B_KF]),
    .wie_i         (ctrl_o[B_WIE]),
    .kse_i         (ctrl_o[B_KSE]),
    .poff_i        (ctrl_o[B_POFF]),
    .set_wf_o      (set_wf),
    .set_kf_o      (set_kf),
    .clr_poff_o    (clr_poff),
    .pwr_oe_o      (pwr_oe_o),
    .irq_oe_o      (irq_oe_o)
  );
endmodule

// File: tb/wake_kick_seq_tb.sv
module wake_kick_seq_tb;
  localparam int unsigned KS_MIN = 4;
  localparam int unsigned TMO    = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ks_n = 1'b1, alarm = 1'b0, sg = 1'b0, oirq = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] ctrl;
  logic       pwr_oe, irq_oe;
  int         checks = 0, errors = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  wake_kick_seq #(.KS_MIN_CYC(KS_MIN), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ks_n_i(ks_n), .alarm_i(alarm),
    .supply_good_i(sg), .other_irq_i(oirq), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .pwr_oe_o(pwr_oe), .irq_oe_o(irq_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic kick(input int low_cyc);
    @(negedge clk); ks_n = 1'b0;
    wait_cyc(low_cyc);
    ks_n = 1'b1;
    wait_cyc(6);
  endtask

  task automatic strobe_alarm();
    @(negedge clk); alarm = 1'b1;
    @(negedge clk); alarm = 1'b0;
    wait_cyc(2);
  endtask

  task automatic t_reset();
    chk("R10 ctrl", ctrl, 5'b10000);
    chk("R10 pwr", pwr_oe, 0);
    chk("R10 irq", irq_oe, 0);
  endtask

  task automatic t_kick_down();
    wr(5'b11000);
    kick(KS_MIN - 2);
    chk("R1 short pulse kf", ctrl[1], 0);
    chk("R1 short pulse pwr", pwr_oe, 0);
    wr(5'b10000);
    kick(10);
    chk("R2 disabled kf", ctrl[1], 0);
    chk("R2 disabled pwr", pwr_oe, 0);
    wr(5'b11000);
    kick(10);
    chk("R2 kf set", ctrl[1], 1);
    chk("R2 pwr", pwr_oe, 1);
    chk("R4 irq quiet in wait", irq_oe, 0);
    wait_cyc(TMO + 8);
    chk("R4 pwr released", pwr_oe, 0);
    chk("R4 irq quiet", irq_oe, 0);
    chk("R4 kf kept", ctrl[1], 1);
    wr(5'b11000);
    chk("R6 kf cleared", ctrl[1], 0);
  endtask

  task automatic t_wake_power();
    wr(5'b10000);
    strobe_alarm();
    chk("R3 disabled wf", ctrl[0], 0);
    chk("R3 disabled pwr", pwr_oe, 0);
    wr(5'b10100);
    strobe_alarm();
    chk("R3 wf set", ctrl[0], 1);
    chk("R3 pwr", pwr_oe, 1);
    @(negedge clk); sg = 1'b1;
    wait_cyc(3);
    chk("R5 pwr held", pwr_oe, 1);
    chk("R5 poff cleared", ctrl[4], 0);
    chk("R5 irq", irq_oe, 1);
    wr(5'b00111);
    chk("R6 write one keeps wf", ctrl[0], 1);
    chk("R6 write one no kf", ctrl[1], 0);
    wr(5'b00100);
    chk("R6 wf cleared", ctrl[0], 0);
    chk("R6 irq off", irq_oe, 0);
    @(negedge clk); oirq = 1'b1;
    @(negedge clk);
    chk("R7 other irq", irq_oe, 1);
    oirq = 1'b0;
    @(negedge clk);
    chk("R7 other irq off", irq_oe, 0);
    kick(10);
    chk("R7 kf set powered", ctrl[1], 1);
    chk("R7 irq masked", irq_oe, 0);
    wr(5'b00100);
    wr(5'b10100);
    chk("R9 pwr released", pwr_oe, 0);
    strobe_alarm();
    chk("R8 pwr again", pwr_oe, 1);
    chk("R8 poff cleared", ctrl[4], 0);
    chk("R7 irq wake", irq_oe, 1);
    wr(5'b10100);
    chk("R9 pwr off", pwr_oe, 0);
    @(negedge clk); oirq = 1'b1;
    @(negedge clk);
    chk("R9 irq before drop", irq_oe, 1);
    sg = 1'b0;
    @(negedge clk);
    chk("R9 irq released", irq_oe, 0);
    oirq = 1'b0;
  endtask

  task automatic t_other_power();
    wr(5'b10100);
    @(negedge clk); sg = 1'b1;
    wait_cyc(3);
    chk("R8 no request", pwr_oe, 0);
    strobe_alarm();
    chk("R8 event drives pwr", pwr_oe, 1);
    chk("R8 poff cleared", ctrl[4], 0);
    @(negedge clk); sg = 1'b0;
    wait_cyc(2);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_kick_down();
    t_wake_power();
    t_other_power();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule